// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the command sequencer behind the byte-level front end of a serial EEPROM slave. The front end deserialises the SPI bit stream and hands over three things: whole received bytes, one-cycle pulses for chip-select falling and rising, and a flag that says whether the rise came right after a complete byte. The engine decodes the opcode byte. It collects a 16-bit address, sent high byte first, and then carries out one of six commands: set or clear the write-enable latch, read or write the status byte, stream data out of the array, or collect a page of data for programming.

Reads present the byte at the current address on `out_byte` with `out_en` high. Each byte that is clocked through the front end then advances the address. The address wraps at the top of the array. Writes collect up to one page in a buffer. When chip select rises cleanly, only the slots that were received are copied into the array, over a self-timed write cycle whose length is a parameter in clocks. A small protection unit keeps the write-enable latch, the block-protect level and the hardware-lock enable. It grants or refuses array writes and status writes, and it builds the status byte.

The array depth is set by `ADDR_W`. A value of 15 or 16 gives a 32K-byte or 64K-byte part. The default is kept small so that the model memory stays modest.

Top module: `eeprom_cmd_engine`

## Requirements
- R1: After reset, `busy` and `out_en` are low, and a status read returns 0x00.
- R2: An opcode byte is decoded only when its upper nibble is zero, and bit 3 is ignored. The low three bits select the command: 110 set latch, 100 clear latch, 101 status read, 001 status write, 011 array read, 010 page write. Any other byte makes the engine ignore the rest of the select period with `out_en` low, until the next chip-select fall.
- R3: The set-latch and clear-latch opcodes set and clear the write-enable latch, which is seen as status bit 1.
- R4: An array read takes a 16-bit address, high byte first, and ignores the address bits above `ADDR_W`. It then presents one byte per received byte at consecutive addresses and wraps from the top address to 0. Received data bytes do not change the array.
- R5: The status byte reads {lock-enable, 0, 0, 0, protect[1:0], latch, busy} from bit 7 down to bit 0. It reads 0xFF while a write cycle runs, and it repeats for every byte of the status read.
- R6: During a page write, each data byte lands at the current address. Only the low 7 address bits then advance, so the page wraps within itself. Page slots that were not received keep their old array contents.
- R7: A page write or status write is committed only when chip select rises with the byte-aligned flag set and at least one data byte received. Otherwise nothing changes and no write cycle starts.
- R8: A page write or status write opcode given while the latch is clear is ignored. The select period then drives nothing and changes nothing.
- R9: A committed write holds `busy` high for exactly `WRITE_CYCLES` clocks, starting on the clock after the rise, and clears the latch.
- R10: While `busy` is high, every opcode except status read is ignored, including the latch commands.
- R11: Protect level 01 guards the top quarter of the array, 10 the top half and 11 all of it. A page write aimed at a guarded page leaves the array unchanged and starts no write cycle.
- R12: A status write stores data bits 7, 3 and 2 as lock-enable and protect level. It is refused when `wp_n` is low and lock-enable is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_fall | input | 1 | One-cycle pulse: chip select went low |
| cs_rise | input | 1 | One-cycle pulse: chip select went high |
| rise_aligned | input | 1 | Valid with `cs_rise`: the rise followed a complete byte |
| rx_valid | input | 1 | One-cycle pulse: a whole byte was received |
| rx_byte | input | 8 | Received byte, valid with `rx_valid` |
| wp_n | input | 1 | Write-protect pin level, low means protect |
| out_byte | output | 8 | Byte for the front end to shift out next |
| out_en | output | 1 | Serial output should be driven |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
The assertions assume that the front end never pulses `cs_fall`, `cs_rise` and `rx_valid` in the same cycle. They also assume that `rx_valid` only comes between a fall and a rise, and that `WRITE_CYCLES` is at least the page size. The bench drives each event in its own clock, always opening a select period before sending bytes and closing it before opening the next. It only reads array locations that an earlier committed write has defined.

// File: rtl/eeprom_cmd_pkg.sv
// Shared types for the serial EEPROM command engine.
// Assumes: opcode low three bits identify the command once the upper nibble is zero.
package eeprom_cmd_pkg;

    typedef enum logic [3:0] {
        S_IDLE,   // waiting for chip select to fall
        S_OPC,    // next byte is the opcode
        S_AHI,    // next byte is address high
        S_ALO,    // next byte is address low
        S_READ,   // streaming array bytes out
        S_WDATA,  // collecting page bytes
        S_STAT,   // streaming the status byte out
        S_SDATA,  // next byte is the new status value
        S_SDONE,  // status value taken, waiting for rise
        S_IGN     // ignore everything until next fall
    } eng_state_t;

    localparam logic [2:0] OP_SETL  = 3'b110;
    localparam logic [2:0] OP_CLRL  = 3'b100;
    localparam logic [2:0] OP_STRD  = 3'b101;
    localparam logic [2:0] OP_STWR  = 3'b001;
    localparam logic [2:0] OP_ARD   = 3'b011;
    localparam logic [2:0] OP_PGWR  = 3'b010;

endpackage

// File: rtl/eeprom_prot.sv
// Protection unit: write-enable latch, block-protect level and hardware-lock enable.
// Produces the status byte and grants for status and array writes.
// Assumes: the top two address bits of the target page arrive on chk_top.
module eeprom_prot (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_wel,
    input  logic       clr_wel,
    input  logic       st_load,
    input  logic [2:0] st_in,     // {lock-enable, protect[1:0]}
    input  logic       wp_n,
    input  logic       busy,
    input  logic [1:0] chk_top,
    output logic       wel,
    output logic [7:0] st_byte,
    output logic       st_grant,
    output logic       arr_grant
);

    logic       wel_q;
    logic       lock_q;
    logic [1:0] bp_q;
    logic       guarded;

    // Holds the latch and the non-volatile protection fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q  <= 1'b0;
            lock_q <= 1'b0;
            bp_q   <= 2'b00;
        end else begin
            if (st_load) begin
                lock_q <= st_in[2];
                bp_q   <= st_in[1:0];
            end
            if (clr_wel)
                wel_q <= 1'b0;
            else if (set_wel)
                wel_q <= 1'b1;
        end
    end

    // Decides whether the addressed page falls in the guarded region.
    always_comb begin
        unique case (bp_q)
            2'b01:   guarded = (chk_top == 2'b11);
            2'b10:   guarded = chk_top[1];
            2'b11:   guarded = 1'b1;
            default: guarded = 1'b0;
        endcase
    end

    assign wel       = wel_q;
    assign st_byte   = busy ? 8'hFF : {lock_q, 3'b000, bp_q, wel_q, 1'b0};
    assign st_grant  = wel_q && !(lock_q && !wp_n);
    assign arr_grant = wel_q && !guarded;

    AST_HW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !wp_n) |=> (lock_q && $stable(bp_q))); // R12

endmodule

// File: rtl/eeprom_wtimer.sv
// Self-timed write cycle: holds busy for WRITE_CYCLES clocks and walks a page index
// over the first PAGE_BYTES clocks of the cycle for the commit copy.
// Assumes: WRITE_CYCLES >= PAGE_BYTES, PAGE_BYTES a power of two, start only while idle.
module eeprom_wtimer #(
    parameter int WRITE_CYCLES = 200,
    parameter int PAGE_BYTES   = 128,
    localparam int OFF_W = $clog2(PAGE_BYTES),
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [OFF_W-1:0] idx,
    output logic             idx_live
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WRITE_CYCLES - 1);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);
    localparam logic [OFF_W:0]   ONE_STEP = (OFF_W+1)'(1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [OFF_W:0]   step_q;

    // Counts down the cycle length and advances the page walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            step_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= LAST_CNT;
            step_q <= '0;
        end else if (busy_q) begin
            if (cnt_q == '0)
                busy_q <= 1'b0;
            else
                cnt_q <= cnt_q - ONE_CNT;
            if (!step_q[OFF_W])
                step_q <= step_q + ONE_STEP;
        end
    end

    assign busy     = busy_q;
    assign idx      = step_q[OFF_W-1:0];
    assign idx_live = busy_q && !step_q[OFF_W];

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q); // R10

endmodule

// File: rtl/eeprom_pagebuf.sv
// Page staging buffer with one valid flag per slot.
// Assumes: clear and write are never asserted together.
module eeprom_pagebuf #(
    parameter int PAGE_BYTES = 128,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [7:0]       wr_data,
    input  logic [OFF_W-1:0] rd_off,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             any_valid
);

    logic [7:0]            slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;

    // Stores incoming page bytes; data needs no reset.
    always_ff @(posedge clk) begin
        if (wr_en)
            slot_q[wr_off] <= wr_data;
    end

    // Tracks which slots hold a received byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_off] <= 1'b1;
    end

    assign rd_data   = slot_q[rd_off];
    assign rd_valid  = valid_q[rd_off];
    assign any_valid = |valid_q;

    AST_SLOT_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> valid_q[$past(wr_off)]); // R6

endmodule

// File: rtl/eeprom_array.sv
// Byte array: one synchronous write port, one asynchronous read port.
// Assumes: contents are undefined until written.
module eeprom_array #(
    parameter int ADDR_W = 11,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    logic [7:0] cell_q [DEPTH];

    // Writes one byte per clock during a commit.
    always_ff @(posedge clk) begin
        if (we)
            cell_q[waddr] <= wdata;
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/eeprom_cmd_engine.sv
// Command sequencer of a serial EEPROM slave. It consumes bytes and chip-select
// edges from a front end, decodes opcodes, streams reads and stages page writes,
// and commits pages or status over a timed write cycle.
// Assumes: cs_fall, cs_rise and rx_valid never pulse together; 9 <= ADDR_W <= 16;
// the array holds at least four pages.
module eeprom_cmd_engine
    import eeprom_cmd_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int PAGE_BYTES   = 128,
    parameter int WRITE_CYCLES = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_fall,
    input  logic       cs_rise,
    input  logic       rise_aligned,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       wp_n,
    output logic [7:0] out_byte,
    output logic       out_en,
    output logic       busy
);

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - OFF_W;
    localparam logic [ADDR_W-1:0] ONE_A   = ADDR_W'(1);
    localparam logic [OFF_W-1:0]  ONE_OFF = OFF_W'(1);

    eng_state_t        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              is_wr_q;
    logic [2:0]        st_hold_q;
    logic [BASE_W-1:0] base_q;
    logic              page_mode_q;

    logic       byte_ev;
    logic       op_ok;
    logic [2:0] op_lo;
    logic       opc_ev;
    logic       commit_pg;
    logic       commit_st;
    logic       start;
    logic       set_wel;
    logic       clr_wel;
    logic       wel_w;
    logic [7:0] st_byte;
    logic       st_grant;
    logic       arr_grant;

    logic [OFF_W-1:0] tm_idx;
    logic             tm_live;
    logic [7:0]       pb_data;
    logic             pb_valid;
    logic             pb_any;
    logic             arr_we;
    logic [7:0]       arr_rdata;

    // Classifies the current byte event and the commit conditions.
    always_comb begin
        byte_ev   = rx_valid && !cs_fall && !cs_rise;
        op_ok     = (rx_byte[7:4] == 4'h0);
        op_lo     = rx_byte[2:0];
        opc_ev    = byte_ev && (state_q == S_OPC) && op_ok && !busy;
        commit_pg = cs_rise && rise_aligned && (state_q == S_WDATA) && pb_any && arr_grant;
        commit_st = cs_rise && rise_aligned && (state_q == S_SDONE) && st_grant;
        start     = commit_pg || commit_st;
        set_wel   = opc_ev && (op_lo == OP_SETL);
        clr_wel   = (opc_ev && (op_lo == OP_CLRL)) || start;
    end

    // Sequences one select period: opcode, address, then data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            addr_q      <= '0;
            is_wr_q     <= 1'b0;
            st_hold_q   <= '0;
            base_q      <= '0;
            page_mode_q <= 1'b0;
        end else begin
            if (start) begin
                base_q      <= addr_q[ADDR_W-1:OFF_W];
                page_mode_q <= commit_pg;
            end
            if (cs_rise) begin
                state_q <= S_IDLE;
            end else if (cs_fall) begin
                state_q <= S_OPC;
            end else if (rx_valid) begin
                unique case (state_q)
                    S_OPC: begin
                        if (!op_ok || (busy && op_lo != OP_STRD)) begin
                            state_q <= S_IGN;
                        end else begin
                            unique case (op_lo)
                                OP_STRD: state_q <= S_STAT;
                                OP_STWR: state_q <= wel_w ? S_SDATA : S_IGN;
                                OP_ARD: begin
                                    is_wr_q <= 1'b0;
                                    state_q <= S_AHI;
                                end
                                OP_PGWR: begin
                                    is_wr_q <= 1'b1;
                                    state_q <= wel_w ? S_AHI : S_IGN;
                                end
                                default: state_q <= S_IGN;
                            endcase
                        end
                    end
                    S_AHI: begin
                        addr_q[ADDR_W-1:8] <= rx_byte[ADDR_W-9:0];
                        state_q <= S_ALO;
                    end
                    S_ALO: begin
                        addr_q[7:0] <= rx_byte;
                        state_q <= is_wr_q ? S_WDATA : S_READ;
                    end
                    S_READ:  addr_q <= addr_q + ONE_A;
                    S_WDATA: addr_q[OFF_W-1:0] <= addr_q[OFF_W-1:0] + ONE_OFF;
                    S_SDATA: begin
                        st_hold_q <= {rx_byte[7], rx_byte[3:2]};
                        state_q   <= S_SDONE;
                    end
                    default: state_q <= state_q;
                endcase
            end
        end
    end

    eeprom_prot u_prot (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_wel   (set_wel),
        .clr_wel   (clr_wel),
        .st_load   (commit_st),
        .st_in     (st_hold_q),
        .wp_n      (wp_n),
        .busy      (busy),
        .chk_top   (addr_q[ADDR_W-1:ADDR_W-2]),
        .wel       (wel_w),
        .st_byte   (st_byte),
        .st_grant  (st_grant),
        .arr_grant (arr_grant)
    );

    eeprom_wtimer #(
        .WRITE_CYCLES (WRITE_CYCLES),
        .PAGE_BYTES   (PAGE_BYTES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .busy     (busy),
        .idx      (tm_idx),
        .idx_live (tm_live)
    );

    eeprom_pagebuf #(
        .PAGE_BYTES (PAGE_BYTES)
    ) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (opc_ev && (op_lo == OP_PGWR)),
        .wr_en     (byte_ev && (state_q == S_WDATA)),
        .wr_off    (addr_q[OFF_W-1:0]),
        .wr_data   (rx_byte),
        .rd_off    (tm_idx),
        .rd_data   (pb_data),
        .rd_valid  (pb_valid),
        .any_valid (pb_any)
    );

    assign arr_we = tm_live && page_mode_q && pb_valid;

    eeprom_array #(
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr ({base_q, tm_idx}),
        .wdata (pb_data),
        .raddr (addr_q),
        .rdata (arr_rdata)
    );

    assign out_en   = (state_q == S_READ) || (state_q == S_STAT);
    assign out_byte = (state_q == S_READ) ? arr_rdata : st_byte;

    AST_BAD_OPC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ev && state_q == S_OPC && !op_ok) |=> !out_en); // R2
    AST_NO_WEL_IGN: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ev && state_q == S_OPC && op_ok && !wel_w && (op_lo == OP_PGWR || op_lo == OP_STWR))
        |=> (state_q == S_IGN)); // R8
    AST_WE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy); // R9
    AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !wel_w)); // R9
    AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ev && state_q == S_OPC && busy && op_lo != OP_STRD) |=> (!out_en && $stable(wel_w))); // R10
    AST_GUARD_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && state_q == S_WDATA && !arr_grant) |=> !busy); // R11

endmodule

// File: tb/tb_eeprom_cmd_engine.sv
`timescale 1ns/1ps
module tb_eeprom_cmd_engine;

    localparam int AW    = 11;
    localparam int PG    = 128;
    localparam int WC    = 200;
    localparam int AMASK = (1 << AW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_fall = 1'b0;
    logic       cs_rise = 1'b0;
    logic       rise_aligned = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       wp_n = 1'b1;
    logic [7:0] out_byte;
    logic       out_en;
    logic       busy;

    always #2.5 clk = ~clk;

    eeprom_cmd_engine #(.ADDR_W(AW), .PAGE_BYTES(PG), .WRITE_CYCLES(WC)) dut (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .rise_aligned(rise_aligned), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .wp_n(wp_n), .out_byte(out_byte), .out_en(out_en), .busy(busy)
    );

    int n_chk = 0;
    int n_fail = 0;
    int wd = 0;
    bit run = 0;
    bit done = 0;

    // Behavioural reference model.
    int m_mem [1 << AW];
    int m_wel = 0, m_lock = 0, m_bp = 0;
    int m_left = 0;
    bit m_req = 0;
    int mode = 0;   // 0 ignore,1 addr hi,2 addr lo,3 read,4 page data,5 status,6 status data,7 status taken,8 opcode
    int t_addr = 0, t_wr = 0, t_cnt = 0, t_sd = 0;
    int pg [PG];
    bit pv [PG];

    task automatic finish_up;
        done = 1;
        run = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit guarded(int a);
        case (m_bp)
            1: return ((a >> (AW - 2)) & 3) == 3;
            2: return ((a >> (AW - 1)) & 1) == 1;
            3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int stat_exp();
        if (m_left > 0) return 255;
        return (m_lock << 7) | (m_bp << 2) | (m_wel << 1);
    endfunction

    // Model of the write-cycle length.
    always @(posedge clk) begin
        if (m_req) begin
            m_left = WC;
            m_req = 0;
        end else if (m_left > 0) begin
            m_left--;
        end
    end

    // Per-clock comparison of the busy flag (R9).
    always @(negedge clk) begin
        if (run) chk(busy === (m_left > 0), "R9 busy span", int'(busy), int'(m_left > 0));
    end

    // Watchdog.
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog R9 actual=running expected=finished");
            finish_up();
        end
    end

    task automatic csf;
        cs_fall = 1'b1;
        @(posedge clk); @(negedge clk);
        cs_fall = 1'b0;
        mode = 8;
    endtask

    task automatic csr(bit al);
        if (al && mode == 4 && t_cnt > 0 && m_wel == 1 && !guarded(t_addr)) begin
            for (int i = 0; i < PG; i++)
                if (pv[i]) m_mem[(t_addr & ~(PG - 1)) | i] = pg[i];
            m_wel = 0;
            m_req = 1;
        end else if (al && mode == 7 && m_wel == 1 && !(m_lock == 1 && !wp_n)) begin
            m_lock = (t_sd >> 7) & 1;
            m_bp = (t_sd >> 2) & 3;
            m_wel = 0;
            m_req = 1;
        end
        cs_rise = 1'b1;
        rise_aligned = al;
        @(posedge clk); @(negedge clk);
        cs_rise = 1'b0;
        rise_aligned = 1'b0;
        mode = 0;
    endtask

    task automatic xfer(int b, string tag);
        bit en;
        int ex;
        int lo;
        en = (mode == 3 || mode == 5);
        ex = (mode == 3) ? m_mem[t_addr] : stat_exp();
        chk(out_en === en, tag, int'(out_en), int'(en));
        if (en && ex >= 0) chk(out_byte === ex[7:0], tag, int'(out_byte), ex);
        case (mode)
            8: begin
                lo = b & 7;
                if ((b >> 4) != 0 || lo == 0 || lo == 7 || (m_left > 0 && lo != 5)) mode = 0;
                else case (lo)
                    6: begin m_wel = 1; mode = 0; end
                    4: begin m_wel = 0; mode = 0; end
                    5: mode = 5;
                    1: mode = m_wel ? 6 : 0;
                    3: begin t_wr = 0; mode = 1; end
                    default: begin
                        if (m_wel == 1) begin
                            t_wr = 1; mode = 1;
                            for (int i = 0; i < PG; i++) pv[i] = 0;
                        end else mode = 0;
                    end
                endcase
            end
            1: begin t_addr = b << 8; mode = 2; end
            2: begin t_addr = (t_addr | b) & AMASK; t_cnt = 0; mode = t_wr ? 4 : 3; end
            3: t_addr = (t_addr + 1) & AMASK;
            4: begin
                pg[t_addr & (PG - 1)] = b;
                pv[t_addr & (PG - 1)] = 1;
                t_addr = (t_addr & ~(PG - 1)) | ((t_addr + 1) & (PG - 1));
                t_cnt++;
            end
            6: begin t_sd = b; mode = 7; end
            default: ;
        endcase
        rx_valid = 1'b1;
        rx_byte = b[7:0];
        @(posedge clk); @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic cmd1(int op, string tag);
        csf();
        xfer(op, tag);
        csr(1);
    endtask

    task automatic stat_rd(string tag);
        csf();
        xfer(8'h05, tag);
        xfer(8'h00, tag);
        xfer(8'h00, tag);
        csr(1);
    endtask

    task automatic stat_wr(int v, string tag);
        csf();
        xfer(8'h01, tag);
        xfer(v, tag);
        csr(1);
    endtask

    task automatic pg_open(int a, string tag);
        csf();
        xfer(8'h02, tag);
        xfer((a >> 8) & 255, tag);
        xfer(a & 255, tag);
    endtask

    task automatic pg_data(int n, int seed, string tag);
        for (int i = 0; i < n; i++) xfer((seed + i * 7) & 255, tag);
    endtask

    task automatic rd(int a, int n, string tag);
        csf();
        xfer(8'h03, tag);
        xfer((a >> 8) & 255, tag);
        xfer(a & 255, tag);
        for (int i = 0; i < n; i++) xfer(8'hA5, tag);
        csr(1);
    endtask

    task automatic wait_free;
        while (m_left > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) m_mem[i] = -1;
        for (int i = 0; i < PG; i++) pv[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        run = 1;
        @(negedge clk);
        chk(out_en === 1'b0, "R1 out_en after reset", int'(out_en), 0);
        chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        stat_rd("R1 R5 status after reset");

        // R3 latch set and clear; R2 bit 3 ignored.
        cmd1(8'h06, "R3 set latch");
        stat_rd("R3 latch set");
        cmd1(8'h04, "R3 clear latch");
        stat_rd("R3 latch clear");
        cmd1(8'h0E, "R2 bit3 dont care");
        stat_rd("R2 set latch via 0x0E");

        // R6 R9 full page at 0, status during cycle, R10 lockout.
        pg_open(16'h0000, "R6 open");
        pg_data(128, 3, "R6 data");
        csr(1);
        stat_rd("R5 status during cycle");
        rd(16'h0000, 2, "R10 read locked out");
        cmd1(8'h06, "R10 set latch locked out");
        wait_free();
        stat_rd("R9 R10 latch clear after cycle");
        rd(16'h0000, 128, "R4 R6 page 0 readback");

        // Top page then wrap inside the page.
        cmd1(8'h06, "R6 latch");
        pg_open(16'h0780, "R6 open top");
        pg_data(128, 11, "R6 data top");
        csr(1);
        wait_free();
        cmd1(8'h06, "R6 latch");
        pg_open(16'h07F0, "R6 wrap open");
        pg_data(20, 90, "R6 wrap data");
        csr(1);
        wait_free();
        rd(16'h0780, 128, "R6 page wrap readback");
        rd(16'h07F0, 20, "R4 array wrap to 0");
        rd(16'hF7F0, 3, "R4 upper address bits ignored");

        // R6 partial page keeps other slots.
        cmd1(8'h06, "R6 latch");
        pg_open(16'h0010, "R6 partial");
        pg_data(3, 200, "R6 partial data");
        csr(1);
        wait_free();
        rd(16'h0000, 40, "R6 partial readback");

        // R7 unaligned rise and empty page.
        cmd1(8'h06, "R7 latch");
        pg_open(16'h0020, "R7 unaligned");
        pg_data(2, 50, "R7 data");
        csr(0);
        rd(16'h0020, 2, "R7 unaligned no change");
        pg_open(16'h0030, "R7 empty");
        csr(1);
        stat_rd("R7 latch kept after no commit");
        cmd1(8'h04, "R7 clear latch");

        // R8 no latch.
        pg_open(16'h0000, "R8 write no latch");
        pg_data(4, 77, "R8 data ignored");
        csr(1);
        rd(16'h0000, 4, "R8 array unchanged");
        stat_wr(8'h8C, "R8 status write no latch");
        stat_rd("R8 status unchanged");

        // R2 invalid opcodes.
        csf();
        xfer(8'h85, "R2 invalid opcode");
        xfer(8'h03, "R2 quiet after invalid");
        xfer(8'h05, "R2 quiet after invalid");
        csr(1);
        csf();
        xfer(8'h07, "R2 invalid low code");
        xfer(8'h00, "R2 quiet after invalid");
        csr(1);

        // R12 R11 protection.
        cmd1(8'h06, "R12 latch");
        stat_wr(8'hF4, "R12 status write");
        wait_free();
        stat_rd("R12 R5 status fields");
        cmd1(8'h06, "R11 latch");
        pg_open(16'h0780, "R11 quarter guarded");
        pg_data(1, 1, "R11 data");
        csr(1);
        rd(16'h0780, 2, "R11 guarded unchanged");
        pg_open(16'h0400, "R11 outside quarter");
        pg_data(1, 9, "R11 data");
        csr(1);
        wait_free();
        rd(16'h0400, 1, "R11 unguarded written");
        wp_n = 1'b0;
        cmd1(8'h06, "R12 latch");
        stat_wr(8'h00, "R12 locked status write");
        stat_rd("R12 status refused");
        wp_n = 1'b1;
        stat_wr(8'h08, "R12 unlocked status write");
        wait_free();
        stat_rd("R12 half level");
        cmd1(8'h06, "R11 latch");
        pg_open(16'h0400, "R11 half guarded");
        pg_data(1, 33, "R11 data");
        csr(1);
        rd(16'h0400, 1, "R11 half unchanged");
        stat_wr(8'h0C, "R11 all level");
        wait_free();
        cmd1(8'h06, "R11 latch");
        pg_open(16'h0000, "R11 all guarded");
        pg_data(2, 44, "R11 data");
        csr(1);
        rd(16'h0000, 2, "R11 all unchanged");
        stat_wr(8'h00, "R12 restore");
        wait_free();
        stat_rd("R5 status restored");

        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule